// File: doc/BRIEF.md
# Register and Flag Rename Unit

This block sits behind an in-order decoder that presents up to two instructions per cycle. It translates the architectural general-register numbers of each instruction into tags of a larger physical register pool. It also translates the single condition-flag group into tags of a small pool of flag entries. Each flag entry stands for one copy of the negative, zero, carry and overflow flags together with the greater-or-equal bits and the saturation bit. Because every flag-setting instruction receives its own flag entry, two independent compares in a row hold different flag tags and need not wait on one shared status register. The physical tags stay internal to the machine and are never visible to software.

The decode group is offered with per-slot valid bits. The `stall` output is the back-pressure signal, and ready is its inverse. When `stall` is high, no slot of the group is renamed, and the decoder must hold the same group on the next cycle. When `stall` is low, every valid slot is renamed, and the slot's output tags in that same cycle are the result. A group with no valid slot never stalls. The commit port is a plain control port. Each cycle it retires at most one renamed slot, oldest first. It writes that slot's new tags into the committed map and returns that slot's previous tags to the free pools. A flush discards all speculative state: the speculative maps take the committed maps, and both free pools are rebuilt from what the committed maps still use.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i (i = 0..15), and the flag group maps to flag tag 0. Physical tags 16..55 and flag tags 1..7 are free.
- R2: A valid slot with its destination-write bit set is given the lowest-numbered free physical tag. When both slots write, slot 0 gets the lowest free tag and slot 1 the next lowest. When only slot 1 writes, slot 1 gets the lowest free tag.
- R3: Each valid slot reports in `sN_ptag_old` the physical tag its destination register held before this instruction, and in `sN_ftag_old` the flag tag that was current before it.
- R4: A valid slot with its flag-write bit set is given a fresh flag tag, taken lowest-free first and following the same slot order as R2. Two flag writers in one group get two different flag tags.
- R5: Within one group, slot 1's source lookups, its previous-destination lookup and its current flag tag take into account the mapping that slot 0 is assigned in the same cycle.
- R6: `stall` is high exactly when at least one slot is valid and either a flush is present or a free pool cannot supply every register or flag tag the group needs. While `stall` is high, nothing is renamed and no tag is consumed.
- R7: A commit with its destination-write bit sets the committed mapping of that register and returns the old physical tag to the free pool. A commit with its flag-write bit does the same for the flag group. A returned tag can be handed out again from the next cycle on.
- R8: On a flush, the speculative register and flag maps become the committed maps, including a commit presented in the same cycle. The free pools become exactly the tags the committed maps do not use.
- R9: For a valid slot without a destination write, `sN_ptag_d` equals its current destination mapping (the same value as `sN_ptag_old`). For a slot without a flag write, `sN_ftag` equals the current flag tag.
- R10: Source tags `sN_ptag_a` and `sN_ptag_b` are the current speculative mappings, which reflect every rename accepted in earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restore speculative state from committed state |
| stall | output | 1 | Group not accepted this cycle (ready = !stall) |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_src_a | input | 4 | Slot 0 first source register |
| s0_src_b | input | 4 | Slot 0 second source register |
| s0_dst_we | input | 1 | Slot 0 writes a destination register |
| s0_dst | input | 4 | Slot 0 destination register |
| s0_flag_we | input | 1 | Slot 0 writes the flags |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_src_a | input | 4 | Slot 1 first source register |
| s1_src_b | input | 4 | Slot 1 second source register |
| s1_dst_we | input | 1 | Slot 1 writes a destination register |
| s1_dst | input | 4 | Slot 1 destination register |
| s1_flag_we | input | 1 | Slot 1 writes the flags |
| s0_ptag_a | output | 6 | Slot 0 first source physical tag |
| s0_ptag_b | output | 6 | Slot 0 second source physical tag |
| s0_ptag_d | output | 6 | Slot 0 destination physical tag |
| s0_ptag_old | output | 6 | Slot 0 previous destination tag |
| s0_ftag | output | 3 | Slot 0 flag tag (new if it writes flags) |
| s0_ftag_old | output | 3 | Slot 0 flag tag before it |
| s1_ptag_a | output | 6 | Slot 1 first source physical tag |
| s1_ptag_b | output | 6 | Slot 1 second source physical tag |
| s1_ptag_d | output | 6 | Slot 1 destination physical tag |
| s1_ptag_old | output | 6 | Slot 1 previous destination tag |
| s1_ftag | output | 3 | Slot 1 flag tag (new if it writes flags) |
| s1_ftag_old | output | 3 | Slot 1 flag tag before it |
| cm_valid | input | 1 | Commit one renamed slot |
| cm_dst_we | input | 1 | Committed slot wrote a register |
| cm_dst | input | 4 | Committed destination register |
| cm_ptag | input | 6 | Committed new physical tag |
| cm_ptag_old | input | 6 | Physical tag to free |
| cm_flag_we | input | 1 | Committed slot wrote the flags |
| cm_ftag | input | 3 | Committed new flag tag |
| cm_ftag_old | input | 3 | Flag tag to free |

## Verification
All rename outputs and `stall` are combinational. They are due in the same cycle the group is presented, so the bench drives inputs just after the falling edge and compares one time unit later, before the next rising edge. Map and pool updates from a rename, a commit or a flush take effect at the rising edge. The bench's model applies them at that edge as well, so the effect is checked through the outputs of the following cycle. In that following cycle, the effect shows up as source tags, previous tags and the next tag handed out.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_ARCH_REGS  = 16;
  localparam int RN_PHYS_REGS  = 56;
  localparam int RN_FLAG_SLOTS = 8;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int N    = 56,
  parameter int RESV = 16,
  localparam int TW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req0,
  input  logic          req1,
  input  logic          take,
  input  logic          rel,
  input  logic [TW-1:0] rel_tag,
  input  logic          flush,
  input  logic [N-1:0]  flush_free,
  output logic [TW-1:0] tag0,
  output logic [TW-1:0] tag1,
  output logic          ok
);
  logic [N-1:0]  free_q, free_d;
  logic [TW-1:0] f_idx, s_idx;
  logic          f_found, s_found;

  // lowest and second-lowest free entries
  always_comb begin
    f_found = 1'b0; s_found = 1'b0;
    f_idx = '0; s_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (free_q[i]) begin
        if (!f_found) begin
          f_found = 1'b1; f_idx = TW'(i);
        end else if (!s_found) begin
          s_found = 1'b1; s_idx = TW'(i);
        end
      end
    end
    tag0 = f_idx;
    tag1 = req0 ? s_idx : f_idx;
    ok   = (!req0 || f_found) && (!req1 || (req0 ? s_found : f_found));
  end

  always_comb begin
    free_d = free_q;
    if (take && req0) free_d[tag0] = 1'b0;
    if (take && req1) free_d[tag1] = 1'b0;
    if (rel)          free_d[rel_tag] = 1'b1;
    if (flush)        free_d = flush_free;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) free_q[i] <= (i >= RESV);
    end else begin
      free_q <= free_d;
    end
  end

  a_r2_distinct_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req0 && req1) |-> (tag0 != tag1));
  a_r6_grant_only_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ok);
  a_r7_no_double_free: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !flush) |-> !free_q[rel_tag]);
  a_r6_idle_keeps_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !rel && !flush) |=> $stable(free_q));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NARCH = 16,
  parameter int NPHYS = 56,
  localparam int AW   = $clog2(NARCH),
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    s0_a, s0_b, s0_d,
  input  logic [AW-1:0]    s1_a, s1_b, s1_d,
  input  logic             w0_en,
  input  logic [PW-1:0]    w0_tag,
  input  logic             w1_en,
  input  logic [PW-1:0]    w1_tag,
  input  logic             upd,
  input  logic             cm_en,
  input  logic [AW-1:0]    cm_arch,
  input  logic [PW-1:0]    cm_tag,
  input  logic             flush,
  output logic [PW-1:0]    s0_pa, s0_pb, s0_pold,
  output logic [PW-1:0]    s1_pa, s1_pb, s1_pold,
  output logic [NPHYS-1:0] live_next
);
  logic [PW-1:0] spec_q [NARCH];
  logic [PW-1:0] comm_q [NARCH];
  logic [PW-1:0] comm_d [NARCH];

  always_comb begin
    s0_pa   = spec_q[s0_a];
    s0_pb   = spec_q[s0_b];
    s0_pold = spec_q[s0_d];
    s1_pa   = (w0_en && s1_a == s0_d) ? w0_tag : spec_q[s1_a];
    s1_pb   = (w0_en && s1_b == s0_d) ? w0_tag : spec_q[s1_b];
    s1_pold = (w0_en && s1_d == s0_d) ? w0_tag : spec_q[s1_d];
  end

  always_comb begin
    for (int i = 0; i < NARCH; i++) comm_d[i] = comm_q[i];
    if (cm_en) comm_d[cm_arch] = cm_tag;
    live_next = '0;
    for (int i = 0; i < NARCH; i++) live_next[comm_d[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) begin
        spec_q[i] <= PW'(i);
        comm_q[i] <= PW'(i);
      end
    end else begin
      for (int i = 0; i < NARCH; i++) comm_q[i] <= comm_d[i];
      if (flush) begin
        for (int i = 0; i < NARCH; i++) spec_q[i] <= comm_d[i];
      end else if (upd) begin
        if (w0_en) spec_q[s0_d] <= w0_tag;
        if (w1_en) spec_q[s1_d] <= w1_tag;
      end
    end
  end

  a_r10_map_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !upd) |=> $stable(spec_q[0]));
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int NARCH = rn_pkg::RN_ARCH_REGS,
  parameter int NPHYS = rn_pkg::RN_PHYS_REGS,
  parameter int NFLAG = rn_pkg::RN_FLAG_SLOTS,
  localparam int AW   = $clog2(NARCH),
  localparam int PW   = $clog2(NPHYS),
  localparam int FW   = $clog2(NFLAG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  output logic          stall,
  input  logic          s0_valid,
  input  logic [AW-1:0] s0_src_a,
  input  logic [AW-1:0] s0_src_b,
  input  logic          s0_dst_we,
  input  logic [AW-1:0] s0_dst,
  input  logic          s0_flag_we,
  input  logic          s1_valid,
  input  logic [AW-1:0] s1_src_a,
  input  logic [AW-1:0] s1_src_b,
  input  logic          s1_dst_we,
  input  logic [AW-1:0] s1_dst,
  input  logic          s1_flag_we,
  output logic [PW-1:0] s0_ptag_a,
  output logic [PW-1:0] s0_ptag_b,
  output logic [PW-1:0] s0_ptag_d,
  output logic [PW-1:0] s0_ptag_old,
  output logic [FW-1:0] s0_ftag,
  output logic [FW-1:0] s0_ftag_old,
  output logic [PW-1:0] s1_ptag_a,
  output logic [PW-1:0] s1_ptag_b,
  output logic [PW-1:0] s1_ptag_d,
  output logic [PW-1:0] s1_ptag_old,
  output logic [FW-1:0] s1_ftag,
  output logic [FW-1:0] s1_ftag_old,
  input  logic          cm_valid,
  input  logic          cm_dst_we,
  input  logic [AW-1:0] cm_dst,
  input  logic [PW-1:0] cm_ptag,
  input  logic [PW-1:0] cm_ptag_old,
  input  logic          cm_flag_we,
  input  logic [FW-1:0] cm_ftag,
  input  logic [FW-1:0] cm_ftag_old
);
  logic need0, need1, fneed0, fneed1, any_valid, fire;
  logic reg_ok, flag_ok;
  logic [PW-1:0] ptag0, ptag1;
  logic [FW-1:0] ftag0, ftag1;
  logic [FW-1:0] sflag_q, cflag_q, cflag_d;
  logic [NPHYS-1:0] live_next;
  logic [NFLAG-1:0] flag_flush_free;

  assign need0     = s0_valid && s0_dst_we;
  assign need1     = s1_valid && s1_dst_we;
  assign fneed0    = s0_valid && s0_flag_we;
  assign fneed1    = s1_valid && s1_flag_we;
  assign any_valid = s0_valid || s1_valid;
  assign stall     = any_valid && (flush || !reg_ok || !flag_ok);
  assign fire      = any_valid && !stall;

  rn_free_list #(.N(NPHYS), .RESV(NARCH)) u_reg_pool (
    .clk, .rst_n,
    .req0(need0), .req1(need1), .take(fire),
    .rel(cm_valid && cm_dst_we), .rel_tag(cm_ptag_old),
    .flush, .flush_free(~live_next),
    .tag0(ptag0), .tag1(ptag1), .ok(reg_ok)
  );

  rn_free_list #(.N(NFLAG), .RESV(1)) u_flag_pool (
    .clk, .rst_n,
    .req0(fneed0), .req1(fneed1), .take(fire),
    .rel(cm_valid && cm_flag_we), .rel_tag(cm_ftag_old),
    .flush, .flush_free(flag_flush_free),
    .tag0(ftag0), .tag1(ftag1), .ok(flag_ok)
  );

  rn_map_table #(.NARCH(NARCH), .NPHYS(NPHYS)) u_map (
    .clk, .rst_n,
    .s0_a(s0_src_a), .s0_b(s0_src_b), .s0_d(s0_dst),
    .s1_a(s1_src_a), .s1_b(s1_src_b), .s1_d(s1_dst),
    .w0_en(need0), .w0_tag(ptag0),
    .w1_en(need1), .w1_tag(ptag1),
    .upd(fire),
    .cm_en(cm_valid && cm_dst_we), .cm_arch(cm_dst), .cm_tag(cm_ptag),
    .flush,
    .s0_pa(s0_ptag_a), .s0_pb(s0_ptag_b), .s0_pold(s0_ptag_old),
    .s1_pa(s1_ptag_a), .s1_pb(s1_ptag_b), .s1_pold(s1_ptag_old),
    .live_next
  );

  assign s0_ptag_d = need0 ? ptag0 : s0_ptag_old;
  assign s1_ptag_d = need1 ? ptag1 : s1_ptag_old;

  // flag group: single-entry map with in-group forwarding
  assign s0_ftag_old = sflag_q;
  assign s0_ftag     = fneed0 ? ftag0 : sflag_q;
  assign s1_ftag_old = s0_ftag;
  assign s1_ftag     = fneed1 ? ftag1 : s0_ftag;

  assign cflag_d         = (cm_valid && cm_flag_we) ? cm_ftag : cflag_q;
  assign flag_flush_free = ~(NFLAG'(1) << cflag_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sflag_q <= '0;
      cflag_q <= '0;
    end else begin
      cflag_q <= cflag_d;
      if (flush)     sflag_q <= cflag_d;
      else if (fire) sflag_q <= s1_ftag;
    end
  end

  a_r4_fresh_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fneed0) |-> (s0_ftag != s0_ftag_old));
  a_r4_two_flag_writers_differ: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fneed0 && fneed1) |-> (s0_ftag != s1_ftag));
  a_r5_bypass_src: assert property (@(posedge clk) disable iff (!rst_n)
    (need0 && s1_valid && s1_src_a == s0_dst) |-> (s1_ptag_a == s0_ptag_d));
  a_r6_stall_freezes_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> $stable(sflag_q));
  a_r8_flush_restores_flags: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (sflag_q == cflag_q));
endmodule

// File: tb/rn_rename_unit_tb.sv
module rn_rename_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 16, NP = 56, NF = 8;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic stall;
  logic s0_valid = 0, s0_dst_we = 0, s0_flag_we = 0;
  logic s1_valid = 0, s1_dst_we = 0, s1_flag_we = 0;
  logic [3:0] s0_src_a = 0, s0_src_b = 0, s0_dst = 0;
  logic [3:0] s1_src_a = 0, s1_src_b = 0, s1_dst = 0;
  logic [5:0] s0_ptag_a, s0_ptag_b, s0_ptag_d, s0_ptag_old;
  logic [5:0] s1_ptag_a, s1_ptag_b, s1_ptag_d, s1_ptag_old;
  logic [2:0] s0_ftag, s0_ftag_old, s1_ftag, s1_ftag_old;
  logic cm_valid = 0, cm_dst_we = 0, cm_flag_we = 0;
  logic [3:0] cm_dst = 0;
  logic [5:0] cm_ptag = 0, cm_ptag_old = 0;
  logic [2:0] cm_ftag = 0, cm_ftag_old = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rn_rename_unit dut_i (.*);

  typedef struct {bit we; int arch; int tag; int old; bit fwe; int ftag; int fold;} ent_t;
  ent_t q[$];
  int smap[NA], cmap[NA];
  bit pfree[NP], ffree[NF];
  int sf, cf;
  int checks = 0, errors = 0;
  bit cm_pop = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin smap[i] = i; cmap[i] = i; end
    for (int i = 0; i < NP; i++) pfree[i] = (i >= NA);
    for (int i = 0; i < NF; i++) ffree[i] = (i >= 1);
    sf = 0; cf = 0; q.delete();
  endtask

  // evaluate one cycle: compare, clock, update model
  task automatic step(string ph);
    int p1, p2, f1, f2, np, nf;
    bit n0, n1, g0, g1, okp, okf, exp_stall;
    int e0d, e0old, t1, old1, a1, b1, e1d, fc0, e0f, fc1, e1f;
    #1;
    p1 = 0; p2 = 0; np = 0; f1 = 0; f2 = 0; nf = 0;
    for (int i = 0; i < NP; i++) if (pfree[i]) begin
      if (np == 0) p1 = i; else if (np == 1) p2 = i;
      np++;
    end
    for (int i = 0; i < NF; i++) if (ffree[i]) begin
      if (nf == 0) f1 = i; else if (nf == 1) f2 = i;
      nf++;
    end
    n0 = s0_valid && s0_dst_we;  n1 = s1_valid && s1_dst_we;
    g0 = s0_valid && s0_flag_we; g1 = s1_valid && s1_flag_we;
    okp = (int'(n0) + int'(n1)) <= np;
    okf = (int'(g0) + int'(g1)) <= nf;
    exp_stall = (s0_valid || s1_valid) && (flush || !okp || !okf);
    e0old = smap[s0_dst];
    e0d = n0 ? p1 : e0old;
    t1 = n0 ? p2 : p1;
    a1 = (n0 && s1_src_a == s0_dst) ? e0d : smap[s1_src_a];
    b1 = (n0 && s1_src_b == s0_dst) ? e0d : smap[s1_src_b];
    old1 = (n0 && s1_dst == s0_dst) ? e0d : smap[s1_dst];
    e1d = n1 ? t1 : old1;
    fc0 = sf; e0f = g0 ? f1 : sf;
    fc1 = e0f; e1f = g1 ? (g0 ? f2 : f1) : e0f;

    chk({"R6 stall ", ph}, int'(stall), int'(exp_stall));
    if (s0_valid) begin
      chk({"R10 s0_ptag_a ", ph}, int'(s0_ptag_a), smap[s0_src_a]);
      chk({"R10 s0_ptag_b ", ph}, int'(s0_ptag_b), smap[s0_src_b]);
      chk({"R3 s0_ptag_old ", ph}, int'(s0_ptag_old), e0old);
      chk({"R3 s0_ftag_old ", ph}, int'(s0_ftag_old), fc0);
      if (!exp_stall) begin
        chk({n0 ? "R2 s0_ptag_d " : "R9 s0_ptag_d ", ph}, int'(s0_ptag_d), e0d);
        chk({g0 ? "R4 s0_ftag " : "R9 s0_ftag ", ph}, int'(s0_ftag), e0f);
      end
    end
    if (s1_valid) begin
      chk({"R5 s1_ptag_a ", ph}, int'(s1_ptag_a), a1);
      chk({"R5 s1_ptag_b ", ph}, int'(s1_ptag_b), b1);
      chk({"R5 s1_ptag_old ", ph}, int'(s1_ptag_old), old1);
      chk({"R5 s1_ftag_old ", ph}, int'(s1_ftag_old), fc1);
      if (!exp_stall) begin
        chk({n1 ? "R2 s1_ptag_d " : "R9 s1_ptag_d ", ph}, int'(s1_ptag_d), e1d);
        chk({g1 ? "R4 s1_ftag " : "R9 s1_ftag ", ph}, int'(s1_ftag), e1f);
      end
    end

    @(posedge clk);
    if (cm_valid) begin
      ent_t e;
      e = q.pop_front();
      if (e.we) begin cmap[e.arch] = e.tag; pfree[e.old] = 1'b1; end
      if (e.fwe) begin cf = e.ftag; ffree[e.fold] = 1'b1; end
    end
    if (flush) begin
      for (int i = 0; i < NA; i++) smap[i] = cmap[i];
      for (int i = 0; i < NP; i++) pfree[i] = 1'b1;
      for (int i = 0; i < NA; i++) pfree[cmap[i]] = 1'b0;
      for (int i = 0; i < NF; i++) ffree[i] = (i != cf);
      sf = cf;
      q.delete();
    end else if (!exp_stall) begin
      if (s0_valid) begin
        if (n0) begin pfree[e0d] = 1'b0; smap[s0_dst] = e0d; end
        if (g0) ffree[e0f] = 1'b0;
        q.push_back('{n0, int'(s0_dst), e0d, e0old, g0, e0f, fc0});
      end
      if (s1_valid) begin
        if (n1) begin pfree[e1d] = 1'b0; smap[s1_dst] = e1d; end
        if (g1) ffree[e1f] = 1'b0;
        q.push_back('{n1, int'(s1_dst), e1d, old1, g1, e1f, fc1});
      end
      sf = e1f;
    end
    @(negedge clk);
  endtask

  task automatic set_commit(bit en);
    cm_valid = en && (q.size() > 0);
    if (cm_valid) begin
      cm_dst_we = q[0].we; cm_dst = 4'(q[0].arch);
      cm_ptag = 6'(q[0].tag); cm_ptag_old = 6'(q[0].old);
      cm_flag_we = q[0].fwe; cm_ftag = 3'(q[0].ftag); cm_ftag_old = 3'(q[0].fold);
    end else begin
      cm_dst_we = 0; cm_flag_we = 0;
    end
  endtask

  task automatic slot0(bit v, int a, int b, bit we, int d, bit fw);
    s0_valid = v; s0_src_a = 4'(a); s0_src_b = 4'(b);
    s0_dst_we = we; s0_dst = 4'(d); s0_flag_we = fw;
  endtask
  task automatic slot1(bit v, int a, int b, bit we, int d, bit fw);
    s1_valid = v; s1_src_a = 4'(a); s1_src_b = 4'(b);
    s1_dst_we = we; s1_dst = 4'(d); s1_flag_we = fw;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset mapping seen through lookups with no writes
    for (int i = 0; i < NA; i++) begin
      slot0(1, i, NA-1-i, 0, i, 0); slot1(0, 0, 0, 0, 0, 0); set_commit(0);
      step("R1");
    end

    // R7: rename r3, commit it, then p3 comes back lowest
    slot0(1, 0, 1, 1, 3, 0); set_commit(0); step("R7");
    slot0(0, 0, 0, 0, 0, 0); set_commit(1); step("R7");
    slot0(1, 3, 4, 1, 4, 0); set_commit(0); step("R7");

    // R8: speculative r5 discarded by flush with same-cycle commit
    slot0(1, 5, 5, 1, 5, 1); set_commit(0); step("R8");
    slot0(1, 4, 5, 0, 5, 0); set_commit(1); flush = 1; step("R8");
    flush = 0; slot0(1, 4, 5, 1, 6, 1); set_commit(0); step("R8");

    // R5: slot 1 depends on slot 0 inside one group, both set flags
    slot0(1, 1, 2, 1, 2, 1); slot1(1, 2, 2, 1, 2, 1); set_commit(0); step("R5");
    slot0(1, 2, 2, 0, 2, 0); slot1(1, 2, 7, 1, 7, 0); step("R5");

    // R6: exhaust flag pool without commits
    for (int i = 0; i < 6; i++) begin
      slot0(1, i, i, 0, 0, 1); slot1(1, i, i, 0, 0, 1); set_commit(0); step("R6");
    end
    slot0(0, 0, 0, 0, 0, 0); slot1(0, 0, 0, 0, 0, 0); flush = 1; step("R8");
    flush = 0;

    // R10: random traffic
    for (int c = 0; c < 4000; c++) begin
      slot0($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 15),
            $urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 3) == 0);
      slot1($urandom_range(0, 2) != 0, $urandom_range(0, 15), $urandom_range(0, 15),
            $urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 3) == 0);
      set_commit($urandom_range(0, 99) < ((c / 500) % 2 == 0 ? 70 : 25));
      flush = ($urandom_range(0, 99) < 2);
      step("R10");
      flush = 0;
    end
    finish_run();
  end
endmodule